// File: doc/BRIEF.md
# Coefficient Write Port with Double-Buffered Control

This block is the host-facing write side of a multi-stage FIR filter. A synchronous host bus writes either a 16-bit control word or entries of a 128-deep coefficient memory. Writes can be whole words or pairs of bytes. A control-select input steers each write to the control word or to the memory. After reset the block holds itself busy for a fixed recovery time and ignores writes until that time has passed.

The control word is double-buffered. The first control write after reset goes straight into the active word. Every later write waits in a pending word. It moves into the active word on the first sample-clock enable that occurs at or after a toggle of the bank-swap pin. The block also keeps track of which of two coefficient banks the filter reads. The bank can come from the pin, from a control bit, or from automatic alternation on every sample. The result is given as an address offset into the memory. The bank changes only on sample-clock enables.

A read port returns memory contents to the arithmetic datapath, which is outside this block.

Top module: `coef_wport`

## Requirements
- R1: A write is accepted on a rising clock edge only when `cs_n` and `we_n` are both low and `busy` is low. With `ctl_sel` high the write targets the control word; with it low the write targets the coefficient memory.
- R2: `busy` is high while `rst_n` is low. It stays high through the first 21 rising edges after release and reads low after the 22nd edge.
- R3: In word mode (`byte_mode` low), a coefficient write stores all 16 bits of `wr_data` at index `wr_addr[6:0]`. `rd_data` returns the entry at `rd_addr` combinationally.
- R4: In byte mode (`byte_mode` high), an accepted write with `wr_addr[0]`=0 only captures `wr_data[7:0]` as the low byte. An accepted write with `wr_addr[0]`=1 commits {`wr_data[7:0]`, captured low byte}. For coefficients it goes to index `wr_addr[7:1]`; for control it is used as the control word.
- R5: Reset sets the active and pending control words to 16'h8C80. The first control write committed after reset appears on `ctl_word` on the following cycle.
- R6: Every later control write only updates the pending word. A change of `swap_pin` arms a transfer. On the first clock edge with `samp_en` high at or after the change, the pending word becomes active, and `ctl_word` holds its value on every other edge.
- R7: With control bit 5 low, the bank is taken on each `samp_en` edge. Bit 7 = 0 takes it from `swap_pin`; bit 7 = 1 takes it from bit 6. Low selects the lower bank and high the upper bank. The bank holds between `samp_en` edges.
- R8: With control bit 5 high, the bank flips on every `samp_en` edge and ignores the pin and bit 6. A `run_start` pulse forces the lower bank on that edge, and this takes priority over `samp_en`.
- R9: The tap count is (bit 15 ? 16 : 8) shifted left by bits 14:13 and again by bit 12. `bank_off` equals the tap count when the upper bank is selected and 0 for the lower bank.
- R10: When the tap count is 128 or more, `bank_off` is 0 whatever bank is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| ctl_sel | input | 1 | High: control word, low: coefficient memory |
| byte_mode | input | 1 | High: byte writes, low: word writes |
| swap_pin | input | 1 | Bank-swap pin, also arms control transfer on change |
| samp_en | input | 1 | One-cycle sample-clock enable |
| run_start | input | 1 | Filter-start pulse, restarts alternation on lower bank |
| rd_addr | input | 7 | Coefficient read index |
| ctl_word | output | 16 | Active control word |
| bank_off | output | 7 | Coefficient address offset of the selected bank |
| busy | output | 1 | Reset recovery in progress, writes ignored |
| rd_data | output | 16 | Coefficient at `rd_addr` |

## Verification
A wrong pending/active state shows on `ctl_word` at the first `samp_en` after a swap toggle. A lost first-write bypass shows on `ctl_word` one cycle after the first control write. A wrong byte-holding register shows as a corrupted value the first time that entry is read. A bank register out of step with its source shows on `bank_off` within one sample period. Because the per-cycle model compares every output on every cycle, each of these faults is reported in the cycle it first becomes visible.

// File: rtl/coef_wport_pkg.sv
package coef_wport_pkg;
  localparam int unsigned CW_DATA_W   = 16;
  localparam int unsigned CW_DEPTH    = 128;
  localparam int unsigned CW_BUSY_CYC = 22;
  localparam logic [15:0] CW_CTL_RST  = 16'h8C80;
endpackage

// File: rtl/coef_wport_wrasm.sv
module coef_wport_wrasm #(
  parameter int unsigned DW    = 16,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             ctl_sel,
  input  logic             byte_mode,
  input  logic [IDX_W:0]   addr,
  input  logic [DW-1:0]    wdata,
  output logic             wr_ctl,
  output logic             wr_coef,
  output logic [IDX_W-1:0] idx,
  output logic [DW-1:0]    word
);
  localparam int unsigned BW = DW / 2;

  logic [BW-1:0] lo_q, lo_d;
  logic          commit;

  always_comb begin
    lo_d = lo_q;
    if (accept && byte_mode && !addr[0]) lo_d = wdata[BW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_d;
  end

  assign commit  = accept && (!byte_mode || addr[0]);
  assign wr_ctl  = commit && ctl_sel;
  assign wr_coef = commit && !ctl_sel;
  assign word    = byte_mode ? {wdata[BW-1:0], lo_q} : wdata;
  assign idx     = byte_mode ? addr[IDX_W:1] : addr[IDX_W-1:0];
endmodule

// File: rtl/coef_wport_ctl.sv
module coef_wport_ctl #(
  parameter int unsigned DW      = 16,
  parameter logic [DW-1:0] RST_W = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic [DW-1:0] word,
  input  logic          swap_pin,
  input  logic          samp_en,
  output logic [DW-1:0] act,
  output logic          direct
);
  logic [DW-1:0] act_q, act_d, pend_q, pend_d;
  logic          dir_q, dir_d, swp_q, req_q, req_d;
  logic          toggle, xfer;

  assign toggle = swap_pin ^ swp_q;
  assign xfer   = samp_en && (req_q || toggle);

  always_comb begin
    act_d  = act_q;
    pend_d = pend_q;
    dir_d  = dir_q;
    req_d  = req_q;
    if (wr_ctl && dir_q) act_d = word;
    else if (xfer)       act_d = pend_q;
    if (wr_ctl) begin
      pend_d = word;
      dir_d  = 1'b0;
    end
    if (xfer)        req_d = 1'b0;
    else if (toggle) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= RST_W;
      pend_q <= RST_W;
      dir_q  <= 1'b1;
      swp_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      dir_q  <= dir_d;
      swp_q  <= swap_pin;
      req_q  <= req_d;
    end
  end

  assign act    = act_q;
  assign direct = dir_q;
endmodule

// File: rtl/coef_wport_bank.sv
module coef_wport_bank #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             single,
  input  logic [1:0]       rate,
  input  logic             decim,
  input  logic             src_reg,
  input  logic             reg_upper,
  input  logic             alt,
  input  logic             swap_pin,
  input  logic             samp_en,
  input  logic             run_start,
  output logic             bank_upper,
  output logic [IDX_W-1:0] bank_off
);
  localparam int unsigned TW    = IDX_W + 2;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic          bank_q, bank_d;
  logic [TW-1:0] taps;

  always_comb begin
    bank_d = bank_q;
    if (run_start)    bank_d = 1'b0;
    else if (samp_en) bank_d = alt ? !bank_q : (src_reg ? reg_upper : swap_pin);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= 1'b0;
    else        bank_q <= bank_d;
  end

  always_comb begin
    taps = single ? TW'(16) : TW'(8);
    taps = taps << rate;
    taps = taps << decim;
  end

  assign bank_upper = bank_q;
  assign bank_off   = (bank_q && (taps < TW'(DEPTH))) ? taps[IDX_W-1:0] : '0;
endmodule

// File: rtl/coef_wport_mem.sv
module coef_wport_mem #(
  parameter int unsigned DW    = 16,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wword,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem_q [1 << IDX_W];

  always_ff @(posedge clk) begin
    if (we) mem_q[widx] <= wword;
  end

  assign rdata = mem_q[ridx];
endmodule

// File: rtl/coef_wport.sv
module coef_wport
  import coef_wport_pkg::*;
#(
  parameter int unsigned DW       = CW_DATA_W,
  parameter int unsigned DEPTH    = CW_DEPTH,
  parameter int unsigned BUSY_CYC = CW_BUSY_CYC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH):0]   wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     cs_n,
  input  logic                     we_n,
  input  logic                     ctl_sel,
  input  logic                     byte_mode,
  input  logic                     swap_pin,
  input  logic                     samp_en,
  input  logic                     run_start,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DW-1:0]            ctl_word,
  output logic [$clog2(DEPTH)-1:0] bank_off,
  output logic                     busy,
  output logic [DW-1:0]            rd_data
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BUSY_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept, wr_ctl, wr_coef, ctl_direct, bank_upper;
  logic [IDX_W-1:0] widx;
  logic [DW-1:0]    wword;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != CNT_END) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy   = (cnt_q != CNT_END);
  assign accept = !cs_n && !we_n && !busy;

  coef_wport_wrasm #(.DW(DW), .IDX_W(IDX_W)) u_wrasm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .ctl_sel(ctl_sel),
    .byte_mode(byte_mode), .addr(wr_addr), .wdata(wr_data),
    .wr_ctl(wr_ctl), .wr_coef(wr_coef), .idx(widx), .word(wword)
  );

  coef_wport_ctl #(.DW(DW), .RST_W(DW'(CW_CTL_RST))) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .word(wword),
    .swap_pin(swap_pin), .samp_en(samp_en), .act(ctl_word),
    .direct(ctl_direct)
  );

  coef_wport_bank #(.IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .single(ctl_word[15]), .rate(ctl_word[14:13]),
    .decim(ctl_word[12]), .src_reg(ctl_word[7]), .reg_upper(ctl_word[6]),
    .alt(ctl_word[5]), .swap_pin(swap_pin), .samp_en(samp_en),
    .run_start(run_start), .bank_upper(bank_upper), .bank_off(bank_off)
  );

  coef_wport_mem #(.DW(DW), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .we(wr_coef), .widx(widx), .wword(wword),
    .ridx(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/coef_wport_chk.sv
module coef_wport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic [15:0] ctl_word,
  input logic        samp_en,
  input logic        run_start,
  input logic        bank_upper,
  input logic        ctl_direct
);
  // R1: nothing reaches the control word while recovering from reset
  p_busy_nowr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctl_word));
  // R2: once clear, busy stays clear until the next reset
  p_busy_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);
  // R6: outside the bypass, the active word moves only on sample enables
  p_ctl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_en && !ctl_direct) |=> $stable(ctl_word));
  // R7: bank holds between sample enables
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_en && !run_start) |=> $stable(bank_upper));
  // R8: start pulse lands on the lower bank
  p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !bank_upper);
  // R8: alternation flips on every sample enable
  p_alt_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_en && !run_start && ctl_word[5]) |=> (bank_upper != $past(bank_upper)));
endmodule

bind coef_wport coef_wport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ctl_word(ctl_word),
  .samp_en(samp_en), .run_start(run_start), .bank_upper(bank_upper),
  .ctl_direct(ctl_direct)
);

// File: tb/coef_wport_tb_top.sv
module coef_wport_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cs_n = 1'b1, we_n = 1'b1, ctl_sel = 1'b0, byte_mode = 1'b0;
  logic        swap_pin = 1'b0, samp_en = 1'b0, run_start = 1'b0;
  logic [6:0]  rd_addr = '0;
  logic [15:0] ctl_word, rd_data;
  logic [6:0]  bank_off;
  logic        busy;

  always #2 clk = ~clk;

  coef_wport dut_i (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .cs_n(cs_n), .we_n(we_n), .ctl_sel(ctl_sel), .byte_mode(byte_mode),
    .swap_pin(swap_pin), .samp_en(samp_en), .run_start(run_start),
    .rd_addr(rd_addr), .ctl_word(ctl_word), .bank_off(bank_off),
    .busy(busy), .rd_data(rd_data)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit samp_on = 1'b0, done = 1'b0;

  // reference model state
  int          m_cnt;
  logic [7:0]  m_lo;
  logic [15:0] m_act, m_pend;
  bit          m_dir, m_swp, m_req, m_bank;
  logic [15:0] m_mem [128];
  bit          m_vld [128];

  function automatic int taps_of(logic [15:0] c);
    int t = c[15] ? 16 : 8;
    t = t << c[14:13];
    t = t << c[12];
    return t;
  endfunction

  function automatic int exp_off();
    int t = taps_of(m_act);
    return (m_bank && t < 128) ? t : 0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_lo = '0; m_act = 16'h8C80; m_pend = 16'h8C80;
    m_dir = 1; m_swp = 0; m_req = 0; m_bank = 0;
  endtask

  task automatic model_edge();
    bit acc, commit, tog, xfer, nb;
    logic [15:0] w;
    int ix;
    acc    = !cs_n && !we_n && (m_cnt >= 22);
    commit = acc && (!byte_mode || wr_addr[0]);
    w      = byte_mode ? {wr_data[7:0], m_lo} : wr_data;
    ix     = byte_mode ? int'(wr_addr[7:1]) : int'(wr_addr[6:0]);
    tog    = (swap_pin != m_swp);
    xfer   = samp_en && (m_req || tog);
    if (run_start)    nb = 0;
    else if (samp_en) nb = m_act[5] ? !m_bank : (m_act[7] ? m_act[6] : swap_pin);
    else              nb = m_bank;
    if (commit && !ctl_sel) begin m_mem[ix] = w; m_vld[ix] = 1; end
    if (commit && ctl_sel && m_dir) m_act = w;
    else if (xfer)                  m_act = m_pend;
    if (commit && ctl_sel) begin m_pend = w; m_dir = 0; end
    if (xfer)     m_req = 0;
    else if (tog) m_req = 1;
    if (acc && byte_mode && !wr_addr[0]) m_lo = wr_data[7:0];
    m_swp  = swap_pin;
    m_bank = nb;
    if (m_cnt < 22) m_cnt++;
  endtask

  task automatic compare();
    check(busy == (m_cnt < 22), "R2 busy", busy, (m_cnt < 22));
    check(ctl_word == m_act, "R6 ctl_word", ctl_word, m_act);
    check(int'(bank_off) == exp_off(), "R9 bank_off", bank_off, exp_off());
    if (m_vld[rd_addr])
      check(rd_data == m_mem[rd_addr], "R3 rd_data", rd_data, m_mem[rd_addr]);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (!rst_n) model_reset(); else model_edge();
    @(negedge clk);
    compare();
    cyc++;
    samp_en = samp_on && (cyc % 4 == 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(bit c, bit bm, logic [7:0] a, logic [15:0] d);
    ctl_sel = c; byte_mode = bm; wr_addr = a; wr_data = d;
    cs_n = 0; we_n = 0;
    step();
    cs_n = 1; we_n = 1;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) m_vld[i] = 0;
    model_reset();
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    idle(20);
    check(ctl_word == 16'h8C80, "R5 reset ctl", ctl_word, 16'h8C80);
    check(busy == 1'b1, "R2 busy in reset", busy, 1);
    rst_n = 1'b1;
    idle(5);
    // R1: control write while busy is ignored, bypass still armed
    wr(1, 0, 8'h00, 16'h0000);
    check(ctl_word == 16'h8C80, "R1 write during busy", ctl_word, 16'h8C80);
    idle(20);
    check(busy == 1'b0, "R2 busy cleared", busy, 0);
    samp_on = 1'b1;
    // R3: word writes
    for (int i = 0; i < 8; i++) wr(0, 0, 8'(i), 16'h1000 + 16'(i * 16'h0111));
    for (int i = 0; i < 8; i++) begin rd_addr = 7'(i); step(); end
    // R4: byte coefficient write at index 10
    wr(0, 1, 8'd20, 16'hAA34);
    wr(0, 1, 8'd21, 16'hBB12);
    rd_addr = 7'd10; step();
    check(rd_data == 16'h1234, "R4 byte coef", rd_data, 16'h1234);
    // R1: cs_n high and we_n high leave index 0 untouched
    ctl_sel = 0; byte_mode = 0; wr_addr = 0; wr_data = 16'hDEAD;
    cs_n = 1; we_n = 0; step();
    cs_n = 0; we_n = 1; step();
    cs_n = 1; we_n = 1;
    rd_addr = 7'd0; step();
    check(rd_data == 16'h1000, "R1 ignored write", rd_data, 16'h1000);
    // R5/R4: first control write, byte mode, goes straight to active
    wr(1, 1, 8'h00, 16'h00C0);
    wr(1, 1, 8'h01, 16'h0020);
    check(ctl_word == 16'h20C0, "R5 direct load", ctl_word, 16'h20C0);
    idle(8); // R7/R9: register-selected upper bank, 16 taps
    check(bank_off == 7'd16, "R9 upper offset", bank_off, 16);
    // R6: second write stays pending
    wr(1, 0, 8'h00, 16'hA000);
    idle(6);
    check(ctl_word == 16'h20C0, "R6 pending held", ctl_word, 16'h20C0);
    swap_pin = 1; idle(8); // R6 transfer, R7 pin source upper
    check(ctl_word == 16'hA000, "R6 transfer", ctl_word, 16'hA000);
    swap_pin = 0; idle(6);
    swap_pin = 1; idle(6);
    // R10: 128 taps with alternation, offset always zero
    wr(1, 0, 8'h00, 16'hE020);
    swap_pin = 0; idle(12);
    // R8: alternation with 16 taps, restart on lower
    wr(1, 0, 8'h00, 16'h2020);
    swap_pin = 1; idle(9);
    run_start = 1; step(); run_start = 0;
    check(bank_off == 7'd0, "R8 start lower", bank_off, 0);
    idle(12);
    // R7: pin source with 8 taps, pin toggling
    wr(1, 0, 8'h00, 16'h0000);
    swap_pin = 0; idle(6);
    swap_pin = 1; idle(6);
    swap_pin = 0; idle(6);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule